// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the divide ratio in the feedback path of a fractional-N frequency synthesizer. It runs on the output clock of an external dual-modulus prescaler. A programmable main count sets how many prescaler output clocks make up one divider cycle. A swallow count sets how many of those clocks, at the start of the cycle, run with the prescaler held at its higher modulus. The block raises one output pulse per divider cycle, which goes to the phase detector.

A first-order delta-sigma accumulator with 1/1024 resolution adds a 10-bit fractional numerator once per divider cycle. Each time the accumulator overflows, that cycle swallows one more prescaler pulse. Over time the average ratio then carries the fraction FN/1024. A band-select input limits the swallow count for the low band. A main count below the legal minimum is raised to the minimum and sets a sticky error output. All three control words are sampled only at the boundary between cycles.

Top module: `fracn_div_ctrl`

## Requirements
- R1: Every divider cycle lasts exactly max(B,2) clocks. `div_pulse` is high for one clock, the last clock of each cycle, and low on every other clock.
- R2: If B is 0 or 1 when a cycle is loaded, that cycle lasts 2 clocks and `b_err` goes high on the next clock. `b_err` then stays high until reset, even after B becomes legal.
- R3: `mod_sel` is high for the first S clocks of a cycle and low for the rest of the cycle.
- R4: The swallow count S of a cycle is A' + c, limited to the cycle length. Here A' is the band-limited swallow word and c is the accumulator carry for that cycle.
- R5: With `band_hi` = 1, A takes its full value 0 to 7. With `band_hi` = 0, any A above 3 is used as 3.
- R6: At each cycle load, the 10-bit accumulator adds FN. A sum of 1024 or more gives carry c = 1 and keeps the sum modulo 1024. With FN held constant, the carries over any 1024 consecutive cycles number exactly FN.
- R7: B, A, FN and `band_hi` are sampled only on the last clock of a cycle. Changing them earlier in a cycle has no effect on that cycle.
- R8: During and after reset, `mod_sel`, `div_pulse` and `b_err` are 0 and the accumulator is 0. The first clock after reset loads a cycle but gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| band_hi | input | 1 | 1 selects the high band (swallow word 0 to 7); 0 selects the low band (swallow word limited to 3) |
| b_word | input | 4 | Main count B; legal values are 2 to 15 |
| a_word | input | 3 | Swallow count A |
| fn_word | input | 10 | Fractional numerator FN, in units of 1/1024 |
| mod_sel | output | 1 | 1 selects the higher prescaler modulus |
| div_pulse | output | 1 | One-clock pulse on the last clock of each divider cycle |
| b_err | output | 1 | Sticky flag: a main count below 2 was loaded |

## Verification
A wrong main counter shows up within one cycle as a `div_pulse` in the wrong clock. A wrong swallow counter shows up in the same cycle as the width of the `mod_sel` run. An accumulator fault is slower to show. It appears only as extra or missing one-clock stretches of `mod_sel` in the cycles that should or should not carry. For that reason the bench holds A at 0 and counts every `mod_sel` clock over 1024 whole cycles for several numerators, and it also compares the outputs clock by clock with a model of the requirements.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int unsigned FRACN_B_MIN    = 2;
    localparam int unsigned FRACN_A_MAX_LO = 3;
endpackage

// File: rtl/fracn_dsm_acc.sv
module fracn_dsm_acc #(
    parameter int unsigned FN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [FN_W-1:0] fn_i,
    output logic            carry_o
);
    typedef struct packed {
        logic [FN_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [FN_W:0] sum;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, fn_i};
        carry_o = sum[FN_W];
        st_d    = st_q;
        if (step_i) begin
            st_d.acc = sum[FN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ZERO_FN_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_i == '0) |-> !carry_o); // R6
endmodule

// File: rtl/fracn_swallow_ctl.sv
module fracn_swallow_ctl #(
    parameter int unsigned B_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [B_W-1:0] len_i,
    input  logic [B_W-1:0] swl_i,
    output logic           bound_o,
    output logic           pulse_o,
    output logic           mod_o
);
    typedef struct packed {
        logic [B_W-1:0] cnt;
        logic [B_W-1:0] swl;
        logic           live;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        if (st_q.cnt == '0) begin
            st_d.cnt = len_i - 1'b1;
            st_d.swl = swl_i;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.swl != '0) begin
                st_d.swl = st_q.swl - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bound_o = (st_q.cnt == '0);
    assign pulse_o = bound_o && st_q.live;
    assign mod_o   = (st_q.swl != '0);

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R1
    AST_SWL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        bound_o |-> (st_q.swl <= 1)); // R4
    AST_MOD_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_o && !bound_o) |=> !mod_o); // R3
    AST_COUNT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bound_o |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R7
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl #(
    parameter int unsigned B_W  = 4,
    parameter int unsigned A_W  = 3,
    parameter int unsigned FN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            band_hi,
    input  logic [B_W-1:0]  b_word,
    input  logic [A_W-1:0]  a_word,
    input  logic [FN_W-1:0] fn_word,
    output logic            mod_sel,
    output logic            div_pulse,
    output logic            b_err
);
    localparam logic [B_W-1:0] B_MIN    = B_W'(fracn_pkg::FRACN_B_MIN);
    localparam logic [A_W-1:0] A_MAX_LO = A_W'(fracn_pkg::FRACN_A_MAX_LO);
    localparam int unsigned    S_W      = (B_W > A_W + 1) ? B_W : A_W + 1;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic           bound;
    logic           carry;
    logic [B_W-1:0] len_eff;
    logic [A_W-1:0] a_lim;
    logic [S_W-1:0] s_sum;
    logic [B_W-1:0] swl_eff;

    always_comb begin
        len_eff = (b_word < B_MIN) ? B_MIN : b_word;
        a_lim   = (!band_hi && (a_word > A_MAX_LO)) ? A_MAX_LO : a_word;
        s_sum   = S_W'(a_lim) + S_W'(carry);
        swl_eff = (s_sum > S_W'(len_eff)) ? len_eff : B_W'(s_sum);
        st_d    = st_q;
        if (bound && (b_word < B_MIN)) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fracn_dsm_acc #(.FN_W(FN_W)) u_dsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (bound),
        .fn_i    (fn_word),
        .carry_o (carry)
    );

    fracn_swallow_ctl #(.B_W(B_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_i   (len_eff),
        .swl_i   (swl_eff),
        .bound_o (bound),
        .pulse_o (div_pulse),
        .mod_o   (mod_sel)
    );

    assign b_err = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        b_err |=> b_err); // R2
    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (bound && (b_word < B_MIN)) |=> b_err); // R2
endmodule

// File: tb/fracn_div_ctrl_tb.sv
module fracn_div_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       band_hi = 1'b1;
    logic [3:0] b_word = 4'd4;
    logic [2:0] a_word = 3'd0;
    logic [9:0] fn_word = 10'd0;
    logic       mod_sel, div_pulse, b_err;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    int m_cnt = 0, m_swl = 0, m_acc = 0;
    bit m_live = 0, m_err = 0;

    always #4 clk = ~clk;

    fracn_div_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .band_hi(band_hi), .b_word(b_word),
        .a_word(a_word), .fn_word(fn_word), .mod_sel(mod_sel),
        .div_pulse(div_pulse), .b_err(b_err)
    );

    function automatic int band_lim(input int a, input bit hi);
        return (!hi && a > 3) ? 3 : a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int be, s, sum, c;
        if (m_cnt == 0) begin
            be = (b_word < 2) ? 2 : int'(b_word);
            if (b_word < 2) m_err = 1;
            sum = m_acc + int'(fn_word);
            c = sum / 1024;
            m_acc = sum % 1024;
            s = band_lim(int'(a_word), band_hi) + c;
            if (s > be) s = be;
            m_cnt = be - 1;
            m_swl = s;
        end else begin
            m_cnt--;
            if (m_swl > 0) m_swl--;
        end
        m_live = 1;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check({cur_req, " pulse"}, int'(div_pulse), int'(m_live && m_cnt == 0));
        check({cur_req, " mod"}, int'(mod_sel), int'(m_swl != 0));
        check({cur_req, " err"}, int'(b_err), int'(m_err));
    endtask

    task automatic wait_pulse();
        int guard = 0;
        do begin tick(); guard++; end while (!div_pulse && guard < 40);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_cnt = 0; m_swl = 0; m_acc = 0; m_live = 0; m_err = 0;
        repeat (2) @(negedge clk);
        check("R8 reset pulse", int'(div_pulse), 0);
        check("R8 reset mod", int'(mod_sel), 0);
        check("R8 reset err", int'(b_err), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int seed = 1234;
        int hi_cnt;
        int first_len;
        int fn_list[5] = '{0, 1, 512, 1023, 683};
        void'($urandom(seed));
        @(negedge clk);
        cur_req = "R8";
        do_reset();
        tick();
        check("R8 first clock no pulse", int'(div_pulse), 0);

        // R5: low band limits A=7 to 3 swallow clocks (FN=0)
        cur_req = "R5";
        band_hi = 0; a_word = 7; b_word = 8; fn_word = 0;
        wait_pulse();
        hi_cnt = 0;
        repeat (8) begin tick(); hi_cnt += int'(mod_sel); end
        check("R5 low band swallow", hi_cnt, 3);
        band_hi = 1;
        wait_pulse();
        hi_cnt = 0;
        repeat (8) begin tick(); hi_cnt += int'(mod_sel); end
        check("R5 high band swallow", hi_cnt, 7);

        // R4: swallow capped at cycle length
        cur_req = "R4";
        b_word = 5; a_word = 7;
        wait_pulse();
        hi_cnt = 0;
        repeat (5) begin tick(); hi_cnt += int'(mod_sel); end
        check("R4 swallow capped", hi_cnt, 5);

        // R7: mid-cycle change of B does not alter the running cycle
        cur_req = "R7";
        a_word = 0; b_word = 9;
        wait_pulse();
        tick(); tick();
        b_word = 3;
        first_len = 2;
        do begin tick(); first_len++; end while (!div_pulse && first_len < 40);
        check("R7 cycle length kept", first_len, 9);

        // R6 / R3: carries over 1024 cycles equal FN
        cur_req = "R6";
        foreach (fn_list[i]) begin
            fn_word = 10'(fn_list[i]); a_word = 0; b_word = 8; band_hi = 1;
            wait_pulse();
            hi_cnt = 0;
            repeat (1024 * 8) begin tick(); hi_cnt += int'(mod_sel); end
            check("R6 carry count", hi_cnt, fn_list[i]);
        end

        // R1 R3 R4 R7: random stimulus, inputs changed at random clocks
        cur_req = "R1";
        repeat (4000) begin
            if ($urandom_range(0, 3) == 0) begin
                b_word  = 4'($urandom_range(2, 15));
                a_word  = 3'($urandom_range(0, 7));
                fn_word = 10'($urandom_range(0, 1023));
                band_hi = 1'($urandom_range(0, 1));
            end
            tick();
        end

        // R2: illegal B loads as 2 and sets sticky error
        cur_req = "R2";
        b_word = 1; a_word = 0; fn_word = 0;
        wait_pulse();
        first_len = 0;
        do begin tick(); first_len++; end while (!div_pulse && first_len < 40);
        check("R2 clamped length", first_len, 2);
        check("R2 err set", int'(b_err), 1);
        b_word = 0;
        repeat (6) tick();
        b_word = 6;
        repeat (20) tick();
        check("R2 err sticky", int'(b_err), 1);

        cur_req = "R8";
        do_reset();
        tick();
        check("R8 err cleared", int'(b_err), 0);
        repeat (30) tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_200_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule